// File: doc/BRIEF.md
# Coprocessor standby and drain controller

This block sits beside a processor core and watches writes to its system control coprocessor. Two register-7 operations are recognised. The first is wait-for-interrupt, which is also reachable through an older register-15 alias. The second is drain-write-buffer.

Wait-for-interrupt removes the core clock enable until a wake event arrives. A wake event is either interrupt line going low, whatever the interrupt mask bits say, or a debug request while debug is enabled. When debug caused the wake, the block raises a debug-entry request so the core enters debug state before it executes anything else. The block also flags when the waking interrupt is unmasked, so the core knows it will take the interrupt first.

Drain-write-buffer holds a pipeline stall until the write buffer reports empty. The write buffer is clocked separately and is never gated by this block, so it can keep draining while the core sleeps. The core pipeline, the write buffer and the interrupt controller sit outside the block.

Top module: `cpStandbyDrain`

## Requirements
- R1: A write strobe with CRn=7, CRm=0, opcode2=4, decoded while running with no wake event present, drives coreClkEn low from the next clock edge.
- R2: A write with CRn=15, CRm=8, opcode2=2 has exactly the same effect as the R1 encoding.
- R3: While asleep, coreClkEn stays low as long as no wake event is sampled. Coprocessor writes made during sleep have no effect, and pipeStall stays low.
- R4: Sampling fiqN or irqN low (active low) during sleep sets coreClkEn high at the next edge. This happens whatever fiqMask and irqMask hold.
- R5: extDbgReq or dbgCtrlReq wakes the block only when dbgEnable is high. With dbgEnable low, either request has no effect.
- R6: A wake taken while a gated debug request is active pulses dbgEntryReq high for one cycle. The pulse lands in the same cycle in which coreClkEn returns.
- R7: At a wake, wakeIntTaken pulses for one cycle only if a low interrupt line has its mask bit low. A mask bit of 1 blocks that line.
- R8: A write with CRn=7, CRm=10, opcode2=4 while wbEmpty is low raises pipeStall from the next edge. pipeStall falls in the cycle after wbEmpty is sampled high.
- R9: The drain encoding decoded while wbEmpty is already high causes no stall cycle.
- R10: A wait-for-interrupt write decoded in a cycle where a wake event is already present leaves coreClkEn high. The R6 and R7 pulses are still produced on the next cycle.
- R11: A synchronous active-high rst makes coreClkEn high and pipeStall, dbgEntryReq and wakeIntTaken low.
- R12: A write with any other field combination, or field values with cpWrEn low, changes no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| cpWrEn | input | 1 | Coprocessor register write strobe |
| cpCrn | input | 4 | Primary register number of the write |
| cpCrm | input | 4 | Secondary register number of the write |
| cpOp2 | input | 3 | Opcode2 field of the write |
| fiqN | input | 1 | Fast interrupt line, active low |
| irqN | input | 1 | Normal interrupt line, active low |
| fiqMask | input | 1 | Fast interrupt disabled when 1 |
| irqMask | input | 1 | Normal interrupt disabled when 1 |
| extDbgReq | input | 1 | External debug request |
| dbgCtrlReq | input | 1 | Debug-request bit from the debug control register |
| dbgEnable | input | 1 | Debug enable, gates debug wake |
| wbEmpty | input | 1 | Write buffer empty flag |
| coreClkEn | output | 1 | Core clock enable |
| pipeStall | output | 1 | Pipeline stall during a drain |
| dbgEntryReq | output | 1 | One-cycle request to enter debug state |
| wakeIntTaken | output | 1 | One-cycle flag: waking interrupt is unmasked |

## Verification
The bench builds the block with its default parameters: 4-bit CRn and CRm, a 3-bit opcode2, and the legacy alias enabled. With these values both sleep encodings, the drain encoding and the near-miss encodings can all be driven at the ports. The variant with the alias removed is never elaborated by the bench. A behavioural model advances on every edge from the same inputs, so the bench checks same-cycle wake, masked wake and gated debug wake against all four outputs cycle by cycle.

// File: rtl/cpStandbyPkg.sv
package cpStandbyPkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_DRAIN = 2'd2
  } ctlState_t;

  // Strobes handed from the decode datapath to the control FSM
  typedef struct packed {
    logic wfiHit;    // sleep encoding (either form) written
    logic drainHit;  // drain encoding written
    logic intWake;   // an interrupt line is low, masks ignored
    logic dbgWake;   // debug request gated by debug enable
    logic intTake;   // a low interrupt line is unmasked
  } opStrobes_t;

endpackage

// File: rtl/cpOpDecode.sv
module cpOpDecode
  import cpStandbyPkg::*;
#(
  parameter int CRN_W     = 4,
  parameter int CRM_W     = 4,
  parameter int OP2_W     = 3,
  parameter bit LEGACY_EN = 1'b1
) (
  input  logic             cpWrEn,
  input  logic [CRN_W-1:0] cpCrn,
  input  logic [CRM_W-1:0] cpCrm,
  input  logic [OP2_W-1:0] cpOp2,
  input  logic             fiqN,
  input  logic             irqN,
  input  logic             fiqMask,
  input  logic             irqMask,
  input  logic             extDbgReq,
  input  logic             dbgCtrlReq,
  input  logic             dbgEnable,
  output opStrobes_t       strobes
);

  localparam logic [CRN_W-1:0] SYS_CRN    = CRN_W'(7);
  localparam logic [CRM_W-1:0] SLEEP_CRM  = CRM_W'(0);
  localparam logic [OP2_W-1:0] SLEEP_OP2  = OP2_W'(4);
  localparam logic [CRM_W-1:0] DRAIN_CRM  = CRM_W'(10);
  localparam logic [OP2_W-1:0] DRAIN_OP2  = OP2_W'(4);
  localparam logic [CRN_W-1:0] ALIAS_CRN  = CRN_W'(15);
  localparam logic [CRM_W-1:0] ALIAS_CRM  = CRM_W'(8);
  localparam logic [OP2_W-1:0] ALIAS_OP2  = OP2_W'(2);

  logic primaryHit;
  logic aliasHit;
  logic drainMatch;

  assign primaryHit = (cpCrn == SYS_CRN) && (cpCrm == SLEEP_CRM) && (cpOp2 == SLEEP_OP2);
  assign drainMatch = (cpCrn == SYS_CRN) && (cpCrm == DRAIN_CRM) && (cpOp2 == DRAIN_OP2);

  generate
    if (LEGACY_EN) begin : g_alias
      assign aliasHit = (cpCrn == ALIAS_CRN) && (cpCrm == ALIAS_CRM) && (cpOp2 == ALIAS_OP2);
    end else begin : g_noAlias
      assign aliasHit = 1'b0;
    end
  endgenerate

  logic fiqLow;
  logic irqLow;
  assign fiqLow = ~fiqN;
  assign irqLow = ~irqN;

  always_comb begin
    strobes          = '0;
    strobes.wfiHit   = cpWrEn && (primaryHit || aliasHit);
    strobes.drainHit = cpWrEn && drainMatch;
    strobes.intWake  = fiqLow || irqLow;
    strobes.dbgWake  = dbgEnable && (extDbgReq || dbgCtrlReq);
    strobes.intTake  = (fiqLow && !fiqMask) || (irqLow && !irqMask);
  end

endmodule

// File: rtl/cpStandbyCtrl.sv
module cpStandbyCtrl
  import cpStandbyPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  opStrobes_t strobes,
  input  logic       wbEmpty,
  output logic       coreClkEn,
  output logic       pipeStall,
  output logic       dbgEntryReq,
  output logic       wakeIntTaken
);

  ctlState_t state;
  ctlState_t stateNext;
  logic      anyWake;
  logic      exitWake;

  assign anyWake = strobes.intWake || strobes.dbgWake;

  always_comb begin
    stateNext = state;
    exitWake  = 1'b0;
    case (state)
      ST_RUN: begin
        if (strobes.wfiHit) begin
          if (anyWake) exitWake = 1'b1;
          else         stateNext = ST_SLEEP;
        end else if (strobes.drainHit && !wbEmpty) begin
          stateNext = ST_DRAIN;
        end
      end
      ST_SLEEP: begin
        if (anyWake) begin
          exitWake  = 1'b1;
          stateNext = ST_RUN;
        end
      end
      ST_DRAIN: begin
        if (wbEmpty) stateNext = ST_RUN;
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_RUN;
      dbgEntryReq  <= 1'b0;
      wakeIntTaken <= 1'b0;
    end else begin
      state        <= stateNext;
      dbgEntryReq  <= exitWake && strobes.dbgWake;
      wakeIntTaken <= exitWake && strobes.intTake;
    end
  end

  assign coreClkEn = (state != ST_SLEEP);
  assign pipeStall = (state == ST_DRAIN);

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (coreClkEn && !pipeStall && strobes.wfiHit && !strobes.intWake && !strobes.dbgWake) |=> !coreClkEn); // R1
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!coreClkEn && !strobes.intWake && !strobes.dbgWake) |=> !coreClkEn); // R3
  AST_NO_STALL_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    !(pipeStall && !coreClkEn)); // R3
  AST_INT_WAKE: assert property (@(posedge clk) disable iff (rst)
    (!coreClkEn && strobes.intWake) |=> coreClkEn); // R4
  AST_DBG_PULSE: assert property (@(posedge clk) disable iff (rst)
    dbgEntryReq |-> coreClkEn); // R6
  AST_DBG_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    dbgEntryReq |=> !dbgEntryReq); // R6
  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pipeStall && !wbEmpty) |=> pipeStall); // R8
  AST_DRAIN_DONE: assert property (@(posedge clk) disable iff (rst)
    (pipeStall && wbEmpty) |=> !pipeStall); // R8
  AST_EMPTY_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    (coreClkEn && !pipeStall && strobes.drainHit && wbEmpty) |=> !pipeStall); // R9
  AST_NO_LOST_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (coreClkEn && !pipeStall && strobes.wfiHit && (strobes.intWake || strobes.dbgWake)) |=> coreClkEn); // R10

endmodule

// File: rtl/cpStandbyDrain.sv
module cpStandbyDrain
  import cpStandbyPkg::*;
#(
  parameter int CRN_W     = 4,
  parameter int CRM_W     = 4,
  parameter int OP2_W     = 3,
  parameter bit LEGACY_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpWrEn,
  input  logic [CRN_W-1:0] cpCrn,
  input  logic [CRM_W-1:0] cpCrm,
  input  logic [OP2_W-1:0] cpOp2,
  input  logic             fiqN,
  input  logic             irqN,
  input  logic             fiqMask,
  input  logic             irqMask,
  input  logic             extDbgReq,
  input  logic             dbgCtrlReq,
  input  logic             dbgEnable,
  input  logic             wbEmpty,
  output logic             coreClkEn,
  output logic             pipeStall,
  output logic             dbgEntryReq,
  output logic             wakeIntTaken
);

  opStrobes_t strobes;

  cpOpDecode #(
    .CRN_W     (CRN_W),
    .CRM_W     (CRM_W),
    .OP2_W     (OP2_W),
    .LEGACY_EN (LEGACY_EN)
  ) i_decode (
    .cpWrEn     (cpWrEn),
    .cpCrn      (cpCrn),
    .cpCrm      (cpCrm),
    .cpOp2      (cpOp2),
    .fiqN       (fiqN),
    .irqN       (irqN),
    .fiqMask    (fiqMask),
    .irqMask    (irqMask),
    .extDbgReq  (extDbgReq),
    .dbgCtrlReq (dbgCtrlReq),
    .dbgEnable  (dbgEnable),
    .strobes    (strobes)
  );

  cpStandbyCtrl i_ctrl (
    .clk          (clk),
    .rst          (rst),
    .strobes      (strobes),
    .wbEmpty      (wbEmpty),
    .coreClkEn    (coreClkEn),
    .pipeStall    (pipeStall),
    .dbgEntryReq  (dbgEntryReq),
    .wakeIntTaken (wakeIntTaken)
  );

endmodule

// File: tb/test_cpStandbyDrain.sv
`timescale 1ns/1ps
module test_cpStandbyDrain;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpWrEn = 1'b0;
  logic [3:0] cpCrn = '0;
  logic [3:0] cpCrm = '0;
  logic [2:0] cpOp2 = '0;
  logic       fiqN = 1'b1;
  logic       irqN = 1'b1;
  logic       fiqMask = 1'b0;
  logic       irqMask = 1'b0;
  logic       extDbgReq = 1'b0;
  logic       dbgCtrlReq = 1'b0;
  logic       dbgEnable = 1'b0;
  logic       wbEmpty = 1'b1;
  logic       coreClkEn;
  logic       pipeStall;
  logic       dbgEntryReq;
  logic       wakeIntTaken;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  string phaseTag = "R11";
  bit    started = 1'b0;

  always #10 clk = ~clk;

  cpStandbyDrain i_cpStandbyDrain (
    .clk(clk), .rst(rst), .cpWrEn(cpWrEn), .cpCrn(cpCrn), .cpCrm(cpCrm), .cpOp2(cpOp2),
    .fiqN(fiqN), .irqN(irqN), .fiqMask(fiqMask), .irqMask(irqMask),
    .extDbgReq(extDbgReq), .dbgCtrlReq(dbgCtrlReq), .dbgEnable(dbgEnable),
    .wbEmpty(wbEmpty), .coreClkEn(coreClkEn), .pipeStall(pipeStall),
    .dbgEntryReq(dbgEntryReq), .wakeIntTaken(wakeIntTaken)
  );

  // Behavioural reference: 0 running, 1 asleep, 2 draining
  int   mState = 0;
  logic eClk = 1'b1, eStall = 1'b0, eDbg = 1'b0, eTake = 1'b0;

  always @(posedge clk) begin
    bit iw, dw, tk, sleepW, drainW, woke;
    int ns;
    iw = !fiqN || !irqN;
    dw = dbgEnable && (extDbgReq || dbgCtrlReq);
    tk = (!fiqN && !fiqMask) || (!irqN && !irqMask);
    sleepW = cpWrEn && ((cpCrn == 7 && cpCrm == 0 && cpOp2 == 4) ||
                        (cpCrn == 15 && cpCrm == 8 && cpOp2 == 2));
    drainW = cpWrEn && cpCrn == 7 && cpCrm == 10 && cpOp2 == 4;
    woke = 1'b0;
    ns = mState;
    if (rst) begin
      ns = 0;
    end else if (mState == 0) begin
      if (sleepW) begin
        if (iw || dw) woke = 1'b1;
        else ns = 1;
      end else if (drainW && !wbEmpty) ns = 2;
    end else if (mState == 1) begin
      if (iw || dw) begin woke = 1'b1; ns = 0; end
    end else begin
      if (wbEmpty) ns = 0;
    end
    mState <= ns;
    eClk   <= (ns != 1);
    eStall <= (ns == 2);
    eDbg   <= !rst && woke && dw;
    eTake  <= !rst && woke && tk;
    started <= 1'b1;
  end

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Compare every output against the model on every falling edge
  always @(negedge clk) begin
    if (started) begin
      check(phaseTag, coreClkEn, eClk, "coreClkEn");
      check(phaseTag, pipeStall, eStall, "pipeStall");
      check(phaseTag, dbgEntryReq, eDbg, "dbgEntryReq");
      check(phaseTag, wakeIntTaken, eTake, "wakeIntTaken");
    end
  end

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
      finishRun();
    end
  end

  task automatic writeOp(input int crn, input int crm, input int op2);
    @(negedge clk);
    cpWrEn = 1'b1; cpCrn = 4'(crn); cpCrm = 4'(crm); cpOp2 = 3'(op2);
    @(negedge clk);
    cpWrEn = 1'b0; cpCrn = '0; cpCrm = '0; cpOp2 = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    // R11: reset values
    check("R11", coreClkEn, 1'b1, "reset coreClkEn");
    check("R11", pipeStall, 1'b0, "reset pipeStall");
    check("R11", dbgEntryReq, 1'b0, "reset dbgEntryReq");
    check("R11", wakeIntTaken, 1'b0, "reset wakeIntTaken");
    idle(2);

    // R1, R3, R4, R7: primary sleep, ignored writes, masked irq wake
    phaseTag = "R1";
    writeOp(7, 0, 4);
    check("R1", coreClkEn, 1'b0, "sleep after primary write");
    phaseTag = "R3";
    idle(3);
    writeOp(7, 10, 4);
    wbEmpty = 1'b0;
    writeOp(7, 0, 4);
    check("R3", coreClkEn, 1'b0, "still asleep after writes");
    check("R3", pipeStall, 1'b0, "no stall while asleep");
    phaseTag = "R4";
    irqMask = 1'b1;
    irqN = 1'b0;
    @(negedge clk);
    check("R4", coreClkEn, 1'b1, "masked irq wakes");
    check("R7", wakeIntTaken, 1'b0, "masked irq not taken");
    irqN = 1'b1; irqMask = 1'b0; wbEmpty = 1'b1;
    idle(2);

    // R2, R7: legacy alias, unmasked fiq wake
    phaseTag = "R2";
    writeOp(15, 8, 2);
    check("R2", coreClkEn, 1'b0, "sleep after legacy write");
    idle(2);
    phaseTag = "R7";
    fiqN = 1'b0;
    @(negedge clk);
    check("R7", wakeIntTaken, 1'b1, "unmasked fiq taken");
    check("R4", coreClkEn, 1'b1, "fiq wakes");
    fiqN = 1'b1;
    @(negedge clk);
    check("R7", wakeIntTaken, 1'b0, "take flag one cycle");
    idle(2);

    // R5, R6: debug gated by enable
    phaseTag = "R5";
    writeOp(7, 0, 4);
    extDbgReq = 1'b1;
    idle(3);
    check("R5", coreClkEn, 1'b0, "debug ignored while disabled");
    check("R5", dbgEntryReq, 1'b0, "no debug entry while disabled");
    phaseTag = "R6";
    dbgEnable = 1'b1;
    @(negedge clk);
    check("R6", coreClkEn, 1'b1, "enabled debug wakes");
    check("R6", dbgEntryReq, 1'b1, "debug entry pulse");
    extDbgReq = 1'b0;
    @(negedge clk);
    check("R6", dbgEntryReq, 1'b0, "debug pulse one cycle");
    idle(2);
    writeOp(15, 8, 2);
    dbgCtrlReq = 1'b1;
    @(negedge clk);
    check("R5", coreClkEn, 1'b1, "control-register request wakes");
    check("R6", dbgEntryReq, 1'b1, "debug entry from control bit");
    dbgCtrlReq = 1'b0; dbgEnable = 1'b0;
    idle(2);

    // R10: wake already present at decode
    phaseTag = "R10";
    irqN = 1'b0;
    writeOp(7, 0, 4);
    check("R10", coreClkEn, 1'b1, "no drop with wake present");
    check("R10", wakeIntTaken, 1'b1, "take flag on same-cycle wake");
    irqN = 1'b1;
    idle(2);
    dbgEnable = 1'b1; extDbgReq = 1'b1;
    writeOp(15, 8, 2);
    check("R10", coreClkEn, 1'b1, "no drop with debug present");
    check("R10", dbgEntryReq, 1'b1, "debug pulse on same-cycle wake");
    extDbgReq = 1'b0; dbgEnable = 1'b0;
    idle(2);

    // R8: drain with non-empty buffer
    phaseTag = "R8";
    wbEmpty = 1'b0;
    writeOp(7, 10, 4);
    check("R8", pipeStall, 1'b1, "stall starts");
    idle(3);
    check("R8", pipeStall, 1'b1, "stall holds while not empty");
    wbEmpty = 1'b1;
    @(negedge clk);
    check("R8", pipeStall, 1'b0, "stall released after empty");
    idle(2);

    // R9: drain with buffer already empty
    phaseTag = "R9";
    writeOp(7, 10, 4);
    check("R9", pipeStall, 1'b0, "no stall when empty");
    idle(2);

    // R12: near-miss encodings and strobe low
    phaseTag = "R12";
    wbEmpty = 1'b0;
    writeOp(7, 0, 3);
    writeOp(15, 8, 3);
    writeOp(7, 11, 4);
    writeOp(6, 0, 4);
    check("R12", coreClkEn, 1'b1, "near-miss ignored");
    check("R12", pipeStall, 1'b0, "near-miss no stall");
    @(negedge clk);
    cpCrn = 4'd7; cpCrm = 4'd0; cpOp2 = 3'd4;
    @(negedge clk);
    cpCrn = 4'd7; cpCrm = 4'd10;
    @(negedge clk);
    cpCrn = '0; cpCrm = '0; cpOp2 = '0;
    check("R12", coreClkEn, 1'b1, "fields without strobe ignored");
    check("R12", pipeStall, 1'b0, "fields without strobe no stall");
    wbEmpty = 1'b1;
    idle(3);

    // R11: reset from sleep
    phaseTag = "R11";
    writeOp(7, 0, 4);
    rst = 1'b1;
    @(negedge clk);
    check("R11", coreClkEn, 1'b1, "reset leaves sleep");
    rst = 1'b0;
    idle(2);

    finishRun();
  end

endmodule